// File: doc/BRIEF.md
# Byte-Loaded Cursor Address Counter

This block holds the address a host uses to reach external display memory. The address is sixteen bits wide and split into two byte lanes. The host can write each lane separately through a byte-wide data input. Every display-data read, display-data write and bit set or clear operation raises a single step strobe, and the counter then moves on by one. The same value also marks where the cursor is drawn.

The counter behaves as a ripple chain. Whenever the top bit of the low lane drops from 1 to 0, the high lane advances by one. This happens on an ordinary step, and it also happens when the host writes a new low byte whose top bit is clear over an old low byte whose top bit was set. As a result, software that reloads the low byte must then reload the high byte. Writing the high byte alone never disturbs the low byte.

Inside the block, a small command decoder gives each lane one of three operations: hold, load or step. The high lane's operation depends on the carry that the low lane reports in the same cycle.

Top module: `cursor_addr_counter`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the address becomes 0x0000. It reads 0x0000 after reset, whatever strobes are present.
- R2: A clock edge with `step` high and both load strobes low raises the address by exactly one. When the low byte goes from 0xFF to 0x00, the high byte advances.
- R3: A step from 0xFFFF wraps the address to 0x0000.
- R4: A low-byte load (`ld_lo` high, `ld_hi` low) copies `din` into address bits 7:0. The high byte is unchanged unless the case in R5 applies.
- R5: If a low-byte load takes address bit 7 from 1 to 0, the high byte (bits 15:8) rises by one in the same edge, wrapping 0xFF to 0x00.
- R6: A high-byte load (`ld_hi` high, `ld_lo` low) copies `din` into bits 15:8, leaves bits 7:0 unchanged, and causes no carry.
- R7: When a load strobe and `step` are high in the same cycle, the load happens and the step is dropped.
- R8: When `ld_lo` and `ld_hi` are both high, both bytes take `din`. The high-byte load takes priority over any carry from the low byte.
- R9: With no strobe high, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_lo | input | 1 | Load `din` into the low address byte |
| ld_hi | input | 1 | Load `din` into the high address byte |
| step | input | 1 | Advance the address by one after a memory access |
| din | input | BYTE_W (8) | Byte supplied by the host for either load |
| addr | output | 2*BYTE_W (16) | Current address for memory access and cursor display |

## Verification
The hardest situation to reach is the carry that a low-byte load pushes into the high byte, because it depends on the old low byte having bit 7 set. The bench first places a known address with a low load followed by a high load. It then issues a low load with a clear bit 7, with the high byte set both to an ordinary value and to 0xFF to cover the wrap. The same preset method sets up collisions of a load with `step`, and of both loads together over a falling bit 7. These show that the step is dropped and that the high load overrides the carry.

// File: rtl/cac_pkg.sv
package cac_pkg;

    // Operation applied to one byte lane in a cycle
    typedef enum logic [1:0] {
        LANE_HOLD = 2'd0,
        LANE_LOAD = 2'd1,
        LANE_STEP = 2'd2
    } lane_cmd_e;

endpackage

// File: rtl/cac_ctrl.sv
module cac_ctrl
    import cac_pkg::*;
(
    input  logic      ld_lo,
    input  logic      ld_hi,
    input  logic      step,
    input  logic      lo_carry,
    output lane_cmd_e lo_cmd,
    output lane_cmd_e hi_cmd
);

    // Low lane: its own load wins; a step is taken only when no load is pending
    always_comb begin
        if (ld_lo) begin
            lo_cmd = LANE_LOAD;
        end else if (step && !ld_hi) begin
            lo_cmd = LANE_STEP;
        end else begin
            lo_cmd = LANE_HOLD;
        end
    end

    // High lane: an explicit load overrides the ripple carry from below
    always_comb begin
        if (ld_hi) begin
            hi_cmd = LANE_LOAD;
        end else if (lo_carry) begin
            hi_cmd = LANE_STEP;
        end else begin
            hi_cmd = LANE_HOLD;
        end
    end

endmodule

// File: rtl/cac_lane.sv
module cac_lane
    import cac_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  lane_cmd_e     cmd,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  q,
    output logic          carry
);

    logic [W-1:0] nxt;

    always_comb begin
        unique case (cmd)
            LANE_LOAD: nxt = din;
            LANE_STEP: nxt = q + W'(1);
            default:   nxt = q;
        endcase
    end

    // Ripple rule: a falling top bit, whatever its cause, feeds the next lane
    assign carry = q[W-1] & ~nxt[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

endmodule

// File: rtl/cursor_addr_counter.sv
module cursor_addr_counter
    import cac_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic                  step,
    input  logic [BYTE_W-1:0]     din,
    output logic [2*BYTE_W-1:0]   addr
);

    localparam int ADDR_W = 2 * BYTE_W;

    lane_cmd_e         lo_cmd;
    lane_cmd_e         hi_cmd;
    logic              lo_carry;
    logic              hi_carry_unused;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    cac_ctrl u_ctrl (
        .ld_lo    (ld_lo),
        .ld_hi    (ld_hi),
        .step     (step),
        .lo_carry (lo_carry),
        .lo_cmd   (lo_cmd),
        .hi_cmd   (hi_cmd)
    );

    cac_lane #(.W(BYTE_W)) u_lo (
        .clk   (clk),
        .rst   (rst),
        .cmd   (lo_cmd),
        .din   (din),
        .q     (lo_q),
        .carry (lo_carry)
    );

    cac_lane #(.W(BYTE_W)) u_hi (
        .clk   (clk),
        .rst   (rst),
        .cmd   (hi_cmd),
        .din   (din),
        .q     (hi_q),
        .carry (hi_carry_unused)
    );

    assign addr = {hi_q, lo_q};

    initial begin
        if (ADDR_W != 2 * BYTE_W) $error("address width mismatch");
    end

endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                ld_lo,
    input logic                ld_hi,
    input logic                step,
    input logic [BYTE_W-1:0]   din,
    input logic [2*BYTE_W-1:0] addr
);

    localparam int ADDR_W = 2 * BYTE_W;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> addr == '0);

    // R2, R3: plain step adds one with wrap
    a_r2_step_adds_one: assert property (@(posedge clk) disable iff (rst)
        (step && !ld_lo && !ld_hi) |=> addr == $past(addr) + ADDR_W'(1));

    // R4, R7: low load without falling bit 7, step ignored
    a_r4_lo_load_plain: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && !ld_hi && !(addr[BYTE_W-1] && !din[BYTE_W-1]))
        |=> addr == {$past(addr[ADDR_W-1:BYTE_W]), $past(din)});

    // R5, R7: low load with falling bit 7 carries into high byte
    a_r5_lo_load_carry: assert property (@(posedge clk) disable iff (rst)
        (ld_lo && !ld_hi && addr[BYTE_W-1] && !din[BYTE_W-1])
        |=> addr == {$past(addr[ADDR_W-1:BYTE_W]) + BYTE_W'(1), $past(din)});

    // R6, R7: high load keeps the low byte
    a_r6_hi_load_keeps_lo: assert property (@(posedge clk) disable iff (rst)
        (ld_hi && !ld_lo) |=> addr == {$past(din), $past(addr[BYTE_W-1:0])});

    // R8
    a_r8_both_loads: assert property (@(posedge clk) disable iff (rst)
        (ld_hi && ld_lo) |=> addr == {$past(din), $past(din)});

    // R9
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!ld_lo && !ld_hi && !step) |=> $stable(addr));

endmodule

bind cursor_addr_counter cac_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .ld_lo (ld_lo),
    .ld_hi (ld_hi),
    .step  (step),
    .din   (din),
    .addr  (addr)
);

// File: tb/cursor_addr_counter_bench.sv
`timescale 1ns/1ps
module cursor_addr_counter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_lo = 1'b0;
    logic        ld_hi = 1'b0;
    logic        step = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [15:0] addr;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    cursor_addr_counter u_cursor_addr_counter (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .step  (step),
        .din   (din),
        .addr  (addr)
    );

    // Drive at falling edge, one rising edge, sample 1 ns after it
    task automatic cyc(input logic r, input logic l, input logic h,
                       input logic s, input logic [7:0] d);
        @(negedge clk);
        rst = r; ld_lo = l; ld_hi = h; step = s; din = d;
        @(posedge clk);
        #1;
        rst = 1'b0; ld_lo = 1'b0; ld_hi = 1'b0; step = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_run++;
        if (addr !== exp) begin
            n_fail++;
            $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
        end
    endtask

    task automatic preset(input logic [15:0] v);
        cyc(0, 1, 0, 0, v[7:0]);
        cyc(0, 0, 1, 0, v[15:8]);
    endtask

    task automatic t_reset;
        cyc(1, 0, 0, 0, 8'h00);
        check("R1 reset", 16'h0000);
        preset(16'h2222);
        cyc(1, 1, 1, 1, 8'h77);
        check("R1 reset over strobes", 16'h0000);
    endtask

    task automatic t_step;
        cyc(0, 0, 0, 1, 8'h00);
        check("R2 step from zero", 16'h0001);
        preset(16'h12FF);
        cyc(0, 0, 0, 1, 8'h00);
        check("R2 step low carry", 16'h1300);
        preset(16'hFFFF);
        cyc(0, 0, 0, 1, 8'h00);
        check("R3 wrap", 16'h0000);
    endtask

    task automatic t_lo_load;
        preset(16'h1300);
        cyc(0, 1, 0, 0, 8'h34);
        check("R4 low load", 16'h1334);
        cyc(0, 1, 0, 0, 8'h80);
        check("R4 rising bit7 no carry", 16'h1380);
        cyc(0, 1, 0, 0, 8'h7F);
        check("R5 falling bit7 carry", 16'h147F);
        preset(16'hFF80);
        cyc(0, 1, 0, 0, 8'h00);
        check("R5 carry wraps high", 16'h0000);
    endtask

    task automatic t_hi_load;
        preset(16'h139C);
        cyc(0, 0, 1, 0, 8'hAB);
        check("R6 high load", 16'hAB9C);
        cyc(0, 0, 1, 0, 8'h01);
        check("R6 high load low kept", 16'h019C);
    endtask

    task automatic t_collide;
        preset(16'h019C);
        cyc(0, 1, 0, 1, 8'h10);
        check("R7 low load beats step", 16'h0210);
        cyc(0, 0, 1, 1, 8'h55);
        check("R7 high load beats step", 16'h5510);
        cyc(0, 1, 0, 0, 8'h90);
        check("R4 setup", 16'h5590);
        cyc(0, 1, 1, 0, 8'h22);
        check("R8 both loads over falling bit7", 16'h2222);
    endtask

    task automatic t_idle;
        preset(16'h4C3D);
        cyc(0, 0, 0, 0, 8'hE1);
        check("R9 idle hold", 16'h4C3D);
        cyc(0, 0, 0, 0, 8'h00);
        check("R9 idle hold again", 16'h4C3D);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_step();
                t_lo_load();
                t_hi_load();
                t_collide();
                t_idle();
                t_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule